// File: doc/BRIEF.md
# PIO Nanosecond-to-Clock Timing Converter

This block turns the nanosecond timing of a programmed-I/O transfer mode into bus-clock counts for two devices sharing one channel, then packs those counts into the byte encodings that a downstream timing generator loads. For each device it takes the address setup time, the active (data pulse) time and the full cycle time, plus a presence flag. The bus frequency in MHz is common to both. One serial divider is shared by all six conversions. Each conversion is a ceiling division by one thousand.

A controller places the timings on the inputs and pulses `start`. The block latches everything, runs the six divisions one after another, and then derives the recovery time. It clamps every count to what the hardware can express. The two devices share one setup field, so their setup counts are merged by taking the larger. When the job ends, the block raises `done` and holds the results until the next accepted `start`.

Top module: `pio_clk_conv`

## Requirements
- R1: A time `t` in ns converts to `floor((t * bus_mhz + 999) / 1000)` clocks, so 80 ns at 40 MHz gives 4 clocks.
- R2: The recovery time in ns is cycle minus setup minus active. If that difference is negative, it is taken as 0 before conversion.
- R3: A present device's setup count is clamped to the range 1 to 4.
- R4: A present device's data (active) count is clamped to the range 1 to 16.
- R5: A present device's recovery count is clamped to the range 2 to 17.
- R6: An absent device (present flag 0) reports setup 1, data 1 and recovery 2, whatever its time inputs are.
- R7: `setup_clk` is the larger of the two devices' clamped setup counts. An absent device counts as 1.
- R8: Each device timing byte holds (data count - 1) in bits 7:4 and (recovery count - 2) in bits 3:0. `misc_byte` holds `prefetch_en` in bit 6 and (`setup_clk` - 1) in bits 5:4. Its bits 7, 3, 2, 1 and 0 are 0.
- R9: A `start` seen while idle latches all inputs, raises `busy` and clears `done`. When the job completes, `busy` falls and `done` rises. `done` and all results then hold until the next accepted `start`, even if the inputs change.
- R10: A `start` seen while `busy` is high is ignored. The running job completes with the values latched when it began.
- R11: After a synchronous active-low reset, `busy` and `done` are 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion job (accepted only when idle) |
| bus_mhz | input | 8 | Bus frequency in MHz |
| prefetch_en | input | 1 | Read-prefetch bit copied into the misc byte |
| dev0_present | input | 1 | Device 0 is attached |
| dev0_setup_ns | input | 12 | Device 0 address setup time, ns |
| dev0_active_ns | input | 12 | Device 0 active pulse time, ns |
| dev0_cycle_ns | input | 12 | Device 0 full cycle time, ns |
| dev1_present | input | 1 | Device 1 is attached |
| dev1_setup_ns | input | 12 | Device 1 address setup time, ns |
| dev1_active_ns | input | 12 | Device 1 active pulse time, ns |
| dev1_cycle_ns | input | 12 | Device 1 full cycle time, ns |
| busy | output | 1 | Job in progress |
| done | output | 1 | Results valid, held until next start |
| setup_clk | output | 3 | Shared setup count, clocks |
| dev0_data_clk | output | 5 | Device 0 data count, clocks |
| dev0_rec_clk | output | 5 | Device 0 recovery count, clocks |
| dev1_data_clk | output | 5 | Device 1 data count, clocks |
| dev1_rec_clk | output | 5 | Device 1 recovery count, clocks |
| dev0_timing_byte | output | 8 | Packed device 0 data/recovery byte |
| dev1_timing_byte | output | 8 | Packed device 1 data/recovery byte |
| misc_byte | output | 8 | Packed shared setup and prefetch byte |

## Verification
The hardest case to create from the ports is a `start` arriving in the middle of a job. The test raises `start` a few cycles after the job begins and presents a different set of timings in the same cycle. It then checks that the finished results still match the first set. A second hard case is the clamp boundaries, including a negative recovery difference. Extreme vectors reach these: timings near the 12-bit limit at 255 MHz, and all-zero timings. A zero bus frequency pushes every present count to its lower clamp.

// File: rtl/pio_conv_pkg.sv
// Package: shared constants and types for the PIO ns-to-clock converter.
// Assumes a fixed 1000 divisor (ns * MHz -> clocks) and the clamp ranges
// of the downstream timing generator.
package pio_conv_pkg;
    localparam int NS_PER_US  = 1000;
    localparam int SETUP_LO   = 1;
    localparam int SETUP_HI   = 4;
    localparam int DATA_LO    = 1;
    localparam int DATA_HI    = 16;
    localparam int REC_LO     = 2;
    localparam int REC_HI     = 17;
    localparam int SETUP_W    = 3;
    localparam int CNT_OUT_W  = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } conv_state_e;

    typedef enum logic [1:0] {
        FLD_SETUP  = 2'd0,
        FLD_ACTIVE = 2'd1,
        FLD_REC    = 2'd2
    } conv_field_e;
endpackage

// File: rtl/pio_ceil_div.sv
// Module: restoring serial divider, one quotient bit per clock.
// Assumes the caller has already added (DIVISOR-1) for round-up.
// start is accepted only when idle; done pulses one cycle when the
// quotient is final. The quotient holds until the next start.
module pio_ceil_div #(
    parameter int DW      = 21,
    parameter int DIVISOR = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int REM_W = $clog2(DIVISOR) + 1;
    localparam int CNT_W = $clog2(DW + 1);

    logic [REM_W-1:0] rem_q, rem_nx;
    logic [DW-1:0]    quo_q, quo_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [REM_W-1:0] trial;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        trial = {rem_q[REM_W-2:0], quo_q[DW-1]};
        if (trial >= REM_W'(DIVISOR)) begin
            rem_nx = trial - REM_W'(DIVISOR);
            quo_nx = {quo_q[DW-2:0], 1'b1};
        end else begin
            rem_nx = trial;
            quo_nx = {quo_q[DW-2:0], 1'b0};
        end
    end

    // Iteration counter, remainder/quotient registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= (cnt_q == CNT_W'(1));
            if (start && cnt_q == '0) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CNT_W'(DW);
            end else if (cnt_q != '0) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign quotient = quo_q;

    // R1: the partial remainder never reaches the divisor
    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q < REM_W'(DIVISOR));
    // R1: done only appears after an iteration has finished
    a_r1_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cnt_q) == CNT_W'(1));
endmodule

// File: rtl/pio_count_clamp.sv
// Module: clamps a raw clock count into [LO, HI].
// Assumes LO <= HI and that HI fits in OUT_W bits.
// An absent device takes ABS_V regardless of the count.
module pio_count_clamp #(
    parameter int IN_W  = 21,
    parameter int OUT_W = 5,
    parameter int LO    = 1,
    parameter int HI    = 16,
    parameter int ABS_V = 1
) (
    input  logic [IN_W-1:0]  raw,
    input  logic             present,
    output logic [OUT_W-1:0] clamped
);
    // Pick the absent value, a bound, or the raw count.
    always_comb begin
        if (!present)
            clamped = OUT_W'(ABS_V);
        else if (raw < IN_W'(LO))
            clamped = OUT_W'(LO);
        else if (raw > IN_W'(HI))
            clamped = OUT_W'(HI);
        else
            clamped = raw[OUT_W-1:0];
    end
endmodule

// File: rtl/pio_merge_pack.sv
// Module: merges the two setup counts and packs the register bytes.
// Assumes data counts >= 1, recovery counts >= 2 and setup counts in 1..4
// (guaranteed by the clamps upstream).
module pio_merge_pack
    import pio_conv_pkg::*;
(
    input  logic [SETUP_W-1:0]   su0,
    input  logic [SETUP_W-1:0]   su1,
    input  logic [CNT_OUT_W-1:0] da0,
    input  logic [CNT_OUT_W-1:0] re0,
    input  logic [CNT_OUT_W-1:0] da1,
    input  logic [CNT_OUT_W-1:0] re1,
    input  logic                 prefetch,
    output logic [SETUP_W-1:0]   su_shared,
    output logic [7:0]           tbyte0,
    output logic [7:0]           tbyte1,
    output logic [7:0]           mbyte
);
    // Larger setup wins; bytes carry offset-encoded counts.
    always_comb begin
        su_shared = (su0 > su1) ? su0 : su1;
        tbyte0    = {4'(da0 - CNT_OUT_W'(1)), 4'(re0 - CNT_OUT_W'(2))};
        tbyte1    = {4'(da1 - CNT_OUT_W'(1)), 4'(re1 - CNT_OUT_W'(2))};
        mbyte     = {1'b0, prefetch, 2'(su_shared - SETUP_W'(1)), 4'b0000};
    end
endmodule

// File: rtl/pio_clk_conv.sv
// Module: top of the PIO ns-to-clock converter.
// Latches both devices' timings on start, runs six ceiling divisions
// through one shared serial divider, then clamps, merges and packs.
// Assumes the inputs need only be valid in the cycle start is accepted.
module pio_clk_conv
    import pio_conv_pkg::*;
#(
    parameter int NS_W  = 12,
    parameter int MHZ_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MHZ_W-1:0]     bus_mhz,
    input  logic                 prefetch_en,
    input  logic                 dev0_present,
    input  logic [NS_W-1:0]      dev0_setup_ns,
    input  logic [NS_W-1:0]      dev0_active_ns,
    input  logic [NS_W-1:0]      dev0_cycle_ns,
    input  logic                 dev1_present,
    input  logic [NS_W-1:0]      dev1_setup_ns,
    input  logic [NS_W-1:0]      dev1_active_ns,
    input  logic [NS_W-1:0]      dev1_cycle_ns,
    output logic                 busy,
    output logic                 done,
    output logic [SETUP_W-1:0]   setup_clk,
    output logic [CNT_OUT_W-1:0] dev0_data_clk,
    output logic [CNT_OUT_W-1:0] dev0_rec_clk,
    output logic [CNT_OUT_W-1:0] dev1_data_clk,
    output logic [CNT_OUT_W-1:0] dev1_rec_clk,
    output logic [7:0]           dev0_timing_byte,
    output logic [7:0]           dev1_timing_byte,
    output logic [7:0]           misc_byte
);
    localparam int PROD_W = NS_W + MHZ_W + 1;
    localparam int NDEV   = 2;
    localparam int NFLD   = 3;

    conv_state_e      state_q;
    logic             dev_q;
    logic [1:0]       fld_q;
    logic [MHZ_W-1:0] mhz_q;
    logic             pf_q;
    logic             pres_q [NDEV];
    logic [NS_W-1:0]  su_ns_q [NDEV];
    logic [NS_W-1:0]  ac_ns_q [NDEV];
    logic [NS_W-1:0]  re_ns_q [NDEV];
    logic [PROD_W-1:0] q_st [NDEV][NFLD];

    logic             in_pres [NDEV];
    logic [NS_W-1:0]  in_su [NDEV];
    logic [NS_W-1:0]  in_ac [NDEV];
    logic [NS_W-1:0]  in_cy [NDEV];
    logic [NS_W-1:0]  in_rec [NDEV];

    logic [NS_W-1:0]   t_sel;
    logic [PROD_W-1:0] operand;
    logic              div_start, div_done;
    logic [PROD_W-1:0] div_q;

    logic [SETUP_W-1:0]   su_c [NDEV];
    logic [CNT_OUT_W-1:0] da_c [NDEV];
    logic [CNT_OUT_W-1:0] re_c [NDEV];
    logic [SETUP_W-1:0]   su_m;
    logic [7:0]           tb0_m, tb1_m, mb_m;

    // Gather the per-device input ports into arrays.
    always_comb begin
        in_pres[0] = dev0_present;   in_pres[1] = dev1_present;
        in_su[0]   = dev0_setup_ns;  in_su[1]   = dev1_setup_ns;
        in_ac[0]   = dev0_active_ns; in_ac[1]   = dev1_active_ns;
        in_cy[0]   = dev0_cycle_ns;  in_cy[1]   = dev1_cycle_ns;
    end

    // Recovery ns = cycle - setup - active, floored at zero.
    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_rec
            logic [NS_W:0] spent;
            always_comb begin
                spent = {1'b0, in_su[d]} + {1'b0, in_ac[d]};
                if (spent > {1'b0, in_cy[d]})
                    in_rec[d] = '0;
                else
                    in_rec[d] = NS_W'({1'b0, in_cy[d]} - spent);
            end
        end
    endgenerate

    // Select the time for the current division and form t*MHz + 999.
    always_comb begin
        case (conv_field_e'(fld_q))
            FLD_SETUP:  t_sel = su_ns_q[dev_q];
            FLD_ACTIVE: t_sel = ac_ns_q[dev_q];
            default:    t_sel = re_ns_q[dev_q];
        endcase
        operand = PROD_W'(t_sel) * PROD_W'(mhz_q) + PROD_W'(NS_PER_US - 1);
    end

    assign div_start = (state_q == ST_ISSUE);

    pio_ceil_div #(.DW(PROD_W), .DIVISOR(NS_PER_US)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (operand),
        .done     (div_done),
        .quotient (div_q)
    );

    // Clamp each device's three counts into its hardware range.
    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_clamp
            pio_count_clamp #(.IN_W(PROD_W), .OUT_W(SETUP_W),
                              .LO(SETUP_LO), .HI(SETUP_HI), .ABS_V(SETUP_LO)) u_su (
                .raw(q_st[d][FLD_SETUP]), .present(pres_q[d]), .clamped(su_c[d]));
            pio_count_clamp #(.IN_W(PROD_W), .OUT_W(CNT_OUT_W),
                              .LO(DATA_LO), .HI(DATA_HI), .ABS_V(DATA_LO)) u_da (
                .raw(q_st[d][FLD_ACTIVE]), .present(pres_q[d]), .clamped(da_c[d]));
            pio_count_clamp #(.IN_W(PROD_W), .OUT_W(CNT_OUT_W),
                              .LO(REC_LO), .HI(REC_HI), .ABS_V(REC_LO)) u_re (
                .raw(q_st[d][FLD_REC]), .present(pres_q[d]), .clamped(re_c[d]));
        end
    endgenerate

    pio_merge_pack u_pack (
        .su0(su_c[0]), .su1(su_c[1]),
        .da0(da_c[0]), .re0(re_c[0]),
        .da1(da_c[1]), .re1(re_c[1]),
        .prefetch(pf_q),
        .su_shared(su_m), .tbyte0(tb0_m), .tbyte1(tb1_m), .mbyte(mb_m)
    );

    // Job sequencer: latch, issue six divisions, store quotients, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dev_q   <= 1'b0;
            fld_q   <= 2'd0;
            mhz_q   <= '0;
            pf_q    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            for (int d = 0; d < NDEV; d++) begin
                pres_q[d]  <= 1'b0;
                su_ns_q[d] <= '0;
                ac_ns_q[d] <= '0;
                re_ns_q[d] <= '0;
                for (int f = 0; f < NFLD; f++) q_st[d][f] <= '0;
            end
            setup_clk        <= '0;
            dev0_data_clk    <= '0;
            dev0_rec_clk     <= '0;
            dev1_data_clk    <= '0;
            dev1_rec_clk     <= '0;
            dev0_timing_byte <= '0;
            dev1_timing_byte <= '0;
            misc_byte        <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    for (int d = 0; d < NDEV; d++) begin
                        pres_q[d]  <= in_pres[d];
                        su_ns_q[d] <= in_su[d];
                        ac_ns_q[d] <= in_ac[d];
                        re_ns_q[d] <= in_rec[d];
                    end
                    mhz_q   <= bus_mhz;
                    pf_q    <= prefetch_en;
                    dev_q   <= 1'b0;
                    fld_q   <= 2'd0;
                    busy    <= 1'b1;
                    done    <= 1'b0;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (div_done) begin
                    q_st[dev_q][fld_q] <= div_q;
                    if (fld_q == 2'(NFLD - 1)) begin
                        fld_q   <= 2'd0;
                        dev_q   <= 1'b1;
                        state_q <= dev_q ? ST_FIN : ST_ISSUE;
                    end else begin
                        fld_q   <= fld_q + 2'd1;
                        state_q <= ST_ISSUE;
                    end
                end
                default: begin
                    setup_clk        <= su_m;
                    dev0_data_clk    <= da_c[0];
                    dev0_rec_clk     <= re_c[0];
                    dev1_data_clk    <= da_c[1];
                    dev1_rec_clk     <= re_c[1];
                    dev0_timing_byte <= tb0_m;
                    dev1_timing_byte <= tb1_m;
                    misc_byte        <= mb_m;
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: busy and done never both high
    a_r9_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R9: results and done hold while no start arrives
    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable({setup_clk, dev0_data_clk, dev0_rec_clk,
            dev1_data_clk, dev1_rec_clk, dev0_timing_byte, dev1_timing_byte, misc_byte})));
    // R10: start during busy leaves the job running
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && state_q != ST_FIN) |=> busy);
    // R3: shared setup stays within 1..4 once published
    a_r3_setup_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (setup_clk >= 3'd1 && setup_clk <= 3'd4));
    // R4: data counts within 1..16
    a_r4_data_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dev0_data_clk >= 5'd1 && dev0_data_clk <= 5'd16 &&
                  dev1_data_clk >= 5'd1 && dev1_data_clk <= 5'd16));
    // R5: recovery counts within 2..17
    a_r5_rec_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dev0_rec_clk >= 5'd2 && dev0_rec_clk <= 5'd17 &&
                  dev1_rec_clk >= 5'd2 && dev1_rec_clk <= 5'd17));
    // R8: unused misc byte bits stay zero
    a_r8_misc_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        misc_byte[7] == 1'b0 && misc_byte[3:0] == 4'b0000);
endmodule

// File: tb/tb_pio_clk_conv.sv
module tb_pio_clk_conv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] bus_mhz = '0;
    logic prefetch_en = 1'b0;
    logic dev0_present = 1'b0, dev1_present = 1'b0;
    logic [11:0] dev0_setup_ns = '0, dev0_active_ns = '0, dev0_cycle_ns = '0;
    logic [11:0] dev1_setup_ns = '0, dev1_active_ns = '0, dev1_cycle_ns = '0;
    logic busy, done;
    logic [2:0] setup_clk;
    logic [4:0] dev0_data_clk, dev0_rec_clk, dev1_data_clk, dev1_rec_clk;
    logic [7:0] dev0_timing_byte, dev1_timing_byte, misc_byte;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pio_clk_conv dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
        .prefetch_en(prefetch_en),
        .dev0_present(dev0_present), .dev0_setup_ns(dev0_setup_ns),
        .dev0_active_ns(dev0_active_ns), .dev0_cycle_ns(dev0_cycle_ns),
        .dev1_present(dev1_present), .dev1_setup_ns(dev1_setup_ns),
        .dev1_active_ns(dev1_active_ns), .dev1_cycle_ns(dev1_cycle_ns),
        .busy(busy), .done(done), .setup_clk(setup_clk),
        .dev0_data_clk(dev0_data_clk), .dev0_rec_clk(dev0_rec_clk),
        .dev1_data_clk(dev1_data_clk), .dev1_rec_clk(dev1_rec_clk),
        .dev0_timing_byte(dev0_timing_byte), .dev1_timing_byte(dev1_timing_byte),
        .misc_byte(misc_byte)
    );

    typedef struct packed {
        logic p0, p1, pf;
        logic [11:0] s0, a0, c0, s1, a1, c1;
        logic [7:0] mhz;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 12'd70,   12'd165,  12'd600,  12'd70,  12'd165,  12'd600, 8'd33},
        '{1'b1, 1'b1, 1'b0, 12'd80,   12'd80,   12'd400,  12'd30,  12'd290,  12'd383, 8'd40},
        '{1'b1, 1'b1, 1'b1, 12'd30,   12'd80,   12'd180,  12'd20,  12'd70,   12'd120, 8'd66},
        '{1'b1, 1'b1, 1'b0, 12'd4000, 12'd4000, 12'd4095, 12'd10,  12'd4095, 12'd200, 8'd255},
        '{1'b1, 1'b1, 1'b1, 12'd0,    12'd0,    12'd0,    12'd0,   12'd0,    12'd0,   8'd10},
        '{1'b1, 1'b0, 1'b1, 12'd50,   12'd125,  12'd240,  12'd90,  12'd90,   12'd90,  8'd100},
        '{1'b0, 1'b1, 1'b0, 12'd500,  12'd500,  12'd2000, 12'd25,  12'd70,   12'd240, 8'd50},
        '{1'b0, 1'b0, 1'b1, 12'd300,  12'd300,  12'd900,  12'd300, 12'd300,  12'd900, 8'd0}
    };

    // Global watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: R9 run did not finish, actual=%0d expected<=150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int ceil_clk(int t, int m);
        return (t * m + 999) / 1000;
    endfunction

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        dev0_present = v.p0; dev1_present = v.p1; prefetch_en = v.pf;
        dev0_setup_ns = v.s0; dev0_active_ns = v.a0; dev0_cycle_ns = v.c0;
        dev1_setup_ns = v.s1; dev1_active_ns = v.a1; dev1_cycle_ns = v.c1;
        bus_mhz = v.mhz;
    endtask

    // Expected values straight from R1..R8.
    task automatic check_results(vec_t v, string tag);
        int su [2]; int da [2]; int re [2];
        int s [2]; int a [2]; int c [2]; int p [2];
        int ax, rn;
        s[0] = int'(v.s0); a[0] = int'(v.a0); c[0] = int'(v.c0); p[0] = int'(v.p0);
        s[1] = int'(v.s1); a[1] = int'(v.a1); c[1] = int'(v.c1); p[1] = int'(v.p1);
        for (int d = 0; d < 2; d++) begin
            if (p[d] != 0) begin
                rn = c[d] - s[d] - a[d];
                if (rn < 0) rn = 0;                                   // R2
                su[d] = clampi(ceil_clk(s[d], int'(v.mhz)), 1, 4);    // R1 R3
                da[d] = clampi(ceil_clk(a[d], int'(v.mhz)), 1, 16);   // R4
                re[d] = clampi(ceil_clk(rn, int'(v.mhz)), 2, 17);     // R5
            end else begin
                su[d] = 1; da[d] = 1; re[d] = 2;                      // R6
            end
        end
        ax = (su[0] > su[1]) ? su[0] : su[1];
        chk({"R7 shared setup ", tag}, int'(setup_clk), ax);
        chk({"R4/R6 dev0 data ", tag}, int'(dev0_data_clk), da[0]);
        chk({"R5/R2 dev0 rec ", tag}, int'(dev0_rec_clk), re[0]);
        chk({"R4/R6 dev1 data ", tag}, int'(dev1_data_clk), da[1]);
        chk({"R5/R2 dev1 rec ", tag}, int'(dev1_rec_clk), re[1]);
        chk({"R8 dev0 byte ", tag}, int'(dev0_timing_byte), ((da[0] - 1) << 4) | (re[0] - 2));
        chk({"R8 dev1 byte ", tag}, int'(dev1_timing_byte), ((da[1] - 1) << 4) | (re[1] - 2));
        chk({"R8 misc byte ", tag}, int'(misc_byte), (int'(v.pf) << 6) | ((ax - 1) << 4));
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk); n++;
        end
        if (done !== 1'b1) begin
            tests++; fails++;
            $display("FAIL R9 %s: done actual=%b expected=1", tag, done);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 done after reset", int'(done), 0);
        chk("R11 setup_clk after reset", int'(setup_clk), 0);
        chk("R11 misc after reset", int'(misc_byte), 0);
        chk("R11 dev0 byte after reset", int'(dev0_timing_byte), 0);

        // Vector table: R1..R8 under several input patterns.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            pulse_start();
            chk("R9 busy during job", int'(busy), 1);
            chk("R9 done cleared by start", int'(done), 0);
            wait_done($sformatf("vec%0d", i));
            chk("R9 busy low at done", int'(busy), 0);
            check_results(VECS[i], $sformatf("vec%0d", i));
        end

        // R1 example: 80 ns at 40 MHz -> 4 clocks (vector 1 setup)
        drive(VECS[1]);
        pulse_start();
        wait_done("r1_example");
        chk("R1 80ns@40MHz setup", int'(setup_clk), 4);

        // R10: start mid-job with different inputs is ignored
        drive(VECS[0]);
        pulse_start();
        repeat (5) @(negedge clk);
        drive(VECS[3]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 still busy after ignored start", int'(busy), 1);
        wait_done("r10_ignored");
        check_results(VECS[0], "R10 ignored start");

        // R9: results hold while inputs change without start
        drive(VECS[2]);
        repeat (10) @(negedge clk);
        chk("R9 done held", int'(done), 1);
        check_results(VECS[0], "R9 hold");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule